// File: doc/BRIEF.md
# Hashed Page Table Search Engine

This block resolves a virtual-to-physical translation by searching a hashed page table that lives in memory. A lookup starts with a virtual page number, a process identifier and the base address of the table. The engine folds the page number and the process identifier into a slot index and adds the table base to form the slot address. It then fetches the slot's eight entries one at a time. An entry hits when it is valid and both of its tags equal the request.

When the first slot holds no match, the engine computes a second slot index with an alternate hash and scans that slot the same way. If neither slot hits, the engine reports a miss, and software then consults its complete backup structure. The entire two-slot search runs without software help.

Memory is reached through a request/response handshake whose latency may vary. Only one read is outstanding at any time. The engine finishes every lookup with a single-cycle completion pulse that carries the hit flag and the physical page number.

Top module: `hashed_pt_walker`

## Requirements
- R1: After a synchronous reset, `busy`, `done` and `mem_req_valid` are all 0.
- R2: The first read of a lookup goes to `tbl_base + (P*8 + 0)`, counted in entry units. P is the primary index: the low IDX_W bits of the VPN XORed with the PID, both zero-extended or truncated to IDX_W bits.
- R3: Within a slot, entries are read in order 0 to 7. Each address is the previous one plus 1, and the next read is issued only after the previous response arrives.
- R4: An entry word is laid out as ppn in bits [PPN_W-1:0], the VPN tag above it, the PID tag above that, and the valid flag in the top bit. An entry hits only if the valid flag is 1 and both tags equal the request.
- R5: The search stops at the first hitting entry. It issues no further reads and returns that entry's PPN.
- R6: If none of the 8 primary entries hits, the engine reads entries 0 to 7 of the alternate slot A = ~P (masked to IDX_W bits).
- R7: If neither slot hits, the engine completes with `hit`=0 and `ppn`=0 after exactly 16 reads.
- R8: `done` is high for exactly one cycle, in the cycle after the deciding response is accepted. `hit` and `ppn` keep their values after the pulse.
- R9: A `start` pulse that arrives while `busy` is 1 is ignored, and the running lookup completes with its own result.
- R10: While `mem_req_valid` is 1 and `mem_req_ready` is 0, the request and its address stay unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a lookup (taken only when idle) |
| vpn | input | VPN_W | Virtual page number to translate |
| pid | input | PID_W | Process identifier |
| tbl_base | input | ADDR_W | Table base address, in entry units |
| busy | output | 1 | Lookup in progress |
| mem_req_valid | output | 1 | Read request valid |
| mem_req_ready | input | 1 | Memory accepts the request |
| mem_req_addr | output | ADDR_W | Entry address being read |
| mem_rsp_valid | input | 1 | Read data valid |
| mem_rsp_data | input | 1+PID_W+VPN_W+PPN_W | Entry word returned by memory |
| done | output | 1 | One-cycle completion pulse |
| hit | output | 1 | Translation found (valid with and after done) |
| ppn | output | PPN_W | Physical page number, 0 on a miss |

## Verification
The bench aims at these corner cases:
- Hits in the first and last entry of a slot. An off-by-one way counter would skip an entry or read a ninth one.
- Hits in the alternate slot. A wrong complement would show up as wrong addresses in reads 9 to 16.
- Entries whose VPN matches but whose PID does not, and entries with matching tags whose valid flag is clear. A partial compare would return a false translation.
- Two valid matches in one slot. An engine that does not stop at the first would report the later PPN or issue extra reads.
- `start` pulses during a running search. An engine that restarts on them would be caught by the address sequence or the final result.

// File: rtl/hpt_pkg.sv
package hpt_pkg;
  typedef enum logic [1:0] {
    ST_IDLE,
    ST_REQ,
    ST_WAIT
  } hpt_state_e;
endpackage

// File: rtl/hpt_hash.sv
module hpt_hash #(
  parameter int VPN_W = 20,
  parameter int PID_W = 8,
  parameter int IDX_W = 6
) (
  input  logic [VPN_W-1:0] vpn,
  input  logic [PID_W-1:0] pid,
  output logic [IDX_W-1:0] prim_idx,
  output logic [IDX_W-1:0] alt_idx
);
  logic [IDX_W-1:0] pid_fit;

  assign pid_fit  = IDX_W'(pid);
  assign prim_idx = vpn[IDX_W-1:0] ^ pid_fit;
  assign alt_idx  = ~prim_idx;
endmodule

// File: rtl/hpt_match.sv
module hpt_match #(
  parameter int VPN_W = 20,
  parameter int PID_W = 8,
  parameter int PPN_W = 20
) (
  input  logic [PID_W+VPN_W+PPN_W:0] entry,
  input  logic [VPN_W-1:0]           vpn,
  input  logic [PID_W-1:0]           pid,
  output logic                       match,
  output logic [PPN_W-1:0]           ppn
);
  localparam int VPN_LO = PPN_W;
  localparam int PID_LO = PPN_W + VPN_W;
  localparam int VLD_B  = PPN_W + VPN_W + PID_W;

  logic             ent_vld;
  logic [VPN_W-1:0] ent_vpn;
  logic [PID_W-1:0] ent_pid;

  assign ent_vld = entry[VLD_B];
  assign ent_vpn = entry[VPN_LO +: VPN_W];
  assign ent_pid = entry[PID_LO +: PID_W];
  assign ppn     = entry[PPN_W-1:0];
  assign match   = ent_vld && (ent_vpn == vpn) && (ent_pid == pid);
endmodule

// File: rtl/hashed_pt_walker.sv
module hashed_pt_walker #(
  parameter int VPN_W  = 20,
  parameter int PID_W  = 8,
  parameter int PPN_W  = 20,
  parameter int IDX_W  = 6,
  parameter int WAYS   = 8,
  parameter int ADDR_W = 32
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       start,
  input  logic [VPN_W-1:0]           vpn,
  input  logic [PID_W-1:0]           pid,
  input  logic [ADDR_W-1:0]          tbl_base,
  output logic                       busy,
  output logic                       mem_req_valid,
  input  logic                       mem_req_ready,
  output logic [ADDR_W-1:0]          mem_req_addr,
  input  logic                       mem_rsp_valid,
  input  logic [PID_W+VPN_W+PPN_W:0] mem_rsp_data,
  output logic                       done,
  output logic                       hit,
  output logic [PPN_W-1:0]           ppn
);
  import hpt_pkg::*;

  localparam int WAY_W = $clog2(WAYS);
  localparam int OFF_W = IDX_W + WAY_W;
  localparam logic [WAY_W-1:0] LAST_WAY = WAY_W'(WAYS - 1);

  hpt_state_e        state_q;
  logic [VPN_W-1:0]  vpn_q;
  logic [PID_W-1:0]  pid_q;
  logic [ADDR_W-1:0] base_q;
  logic [WAY_W-1:0]  way_q;
  logic              second_q;
  logic              done_q, hit_q;
  logic [PPN_W-1:0]  ppn_q;

  logic [IDX_W-1:0]  prim_idx, alt_idx, slot_idx;
  logic              ent_match;
  logic [PPN_W-1:0]  ent_ppn;

  hpt_hash #(.VPN_W(VPN_W), .PID_W(PID_W), .IDX_W(IDX_W)) u_hash (
    .vpn(vpn_q), .pid(pid_q), .prim_idx(prim_idx), .alt_idx(alt_idx)
  );

  hpt_match #(.VPN_W(VPN_W), .PID_W(PID_W), .PPN_W(PPN_W)) u_match (
    .entry(mem_rsp_data), .vpn(vpn_q), .pid(pid_q),
    .match(ent_match), .ppn(ent_ppn)
  );

  assign slot_idx      = second_q ? alt_idx : prim_idx;
  assign mem_req_addr  = base_q + ADDR_W'({slot_idx, way_q});
  assign mem_req_valid = (state_q == ST_REQ);
  assign busy          = (state_q != ST_IDLE);
  assign done          = done_q;
  assign hit           = hit_q;
  assign ppn           = ppn_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q  <= ST_IDLE;
      vpn_q    <= '0;
      pid_q    <= '0;
      base_q   <= '0;
      way_q    <= '0;
      second_q <= 1'b0;
      done_q   <= 1'b0;
      hit_q    <= 1'b0;
      ppn_q    <= '0;
    end else begin
      done_q <= 1'b0;
      unique case (state_q)
        ST_IDLE: begin
          if (start) begin
            vpn_q    <= vpn;
            pid_q    <= pid;
            base_q   <= tbl_base;
            way_q    <= '0;
            second_q <= 1'b0;
            state_q  <= ST_REQ;
          end
        end
        ST_REQ: begin
          if (mem_req_ready) state_q <= ST_WAIT;
        end
        ST_WAIT: begin
          if (mem_rsp_valid) begin
            if (ent_match) begin
              done_q  <= 1'b1;
              hit_q   <= 1'b1;
              ppn_q   <= ent_ppn;
              state_q <= ST_IDLE;
            end else if (way_q != LAST_WAY) begin
              way_q   <= way_q + 1'b1;
              state_q <= ST_REQ;
            end else if (!second_q) begin
              second_q <= 1'b1;
              way_q    <= '0;
              state_q  <= ST_REQ;
            end else begin
              done_q  <= 1'b1;
              hit_q   <= 1'b0;
              ppn_q   <= '0;
              state_q <= ST_IDLE;
            end
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  // R10: a stalled request keeps its address
  a_r10_req_hold: assert property (@(posedge clk) disable iff (rst)
    mem_req_valid && !mem_req_ready |=> mem_req_valid && $stable(mem_req_addr));

  // R8: completion pulse lasts one cycle
  a_r8_done_single: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  // R5: no read in flight once the result is out
  a_r5_quiet_after_done: assert property (@(posedge clk) disable iff (rst)
    done |-> !mem_req_valid);

  // R1: an idle engine issues no reads
  a_r1_idle_quiet: assert property (@(posedge clk) disable iff (rst)
    !busy |-> !mem_req_valid);

  // R7: a miss carries a zero page number
  a_r7_miss_zero: assert property (@(posedge clk) disable iff (rst)
    done && !hit |-> ppn == '0);

  // R9: a start during a search leaves the captured base untouched
  a_r9_start_ignored: assert property (@(posedge clk) disable iff (rst)
    busy && start |=> $stable(base_q));
endmodule

// File: tb/hashed_pt_walker_tb.sv
module hashed_pt_walker_tb;
  localparam int VPN_W = 20, PID_W = 8, PPN_W = 20, IDX_W = 6, ADDR_W = 32;
  localparam int EW = 1 + PID_W + VPN_W + PPN_W;

  logic clk = 1'b0;
  logic rst, start, mem_req_ready, mem_rsp_valid;
  logic [VPN_W-1:0] vpn;
  logic [PID_W-1:0] pid;
  logic [ADDR_W-1:0] tbl_base;
  logic [EW-1:0] mem_rsp_data;
  logic busy, mem_req_valid, done, hit;
  logic [ADDR_W-1:0] mem_req_addr;
  logic [PPN_W-1:0] ppn;

  logic [EW-1:0] mem [512];
  int checks = 0, fails = 0;
  bit finished = 0;

  always #10 clk = ~clk;

  hashed_pt_walker u_dut (
    .clk(clk), .rst(rst), .start(start), .vpn(vpn), .pid(pid), .tbl_base(tbl_base),
    .busy(busy), .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
    .mem_req_addr(mem_req_addr), .mem_rsp_valid(mem_rsp_valid),
    .mem_rsp_data(mem_rsp_data), .done(done), .hit(hit), .ppn(ppn)
  );

  task automatic check(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [EW-1:0] mk(input bit v, input logic [PID_W-1:0] p,
                                       input logic [VPN_W-1:0] vp, input logic [PPN_W-1:0] pp);
    return {v, p, vp, pp};
  endfunction

  function automatic logic [5:0] prim_of(input logic [VPN_W-1:0] vp, input logic [PID_W-1:0] p);
    return vp[5:0] ^ p[5:0];
  endfunction

  function automatic int exp_off(input logic [VPN_W-1:0] vp, input logic [PID_W-1:0] p, input int n);
    logic [5:0] s;
    s = (n < 8) ? prim_of(vp, p) : ~prim_of(vp, p);
    return {s, 3'(n % 8)};
  endfunction

  task automatic expect_search(input logic [VPN_W-1:0] vp, input logic [PID_W-1:0] p,
                               output bit eh, output logic [PPN_W-1:0] ep, output int er);
    eh = 0; ep = '0; er = 16;
    for (int n = 0; n < 16; n++) begin
      logic [EW-1:0] e;
      e = mem[exp_off(vp, p, n)];
      if (e[EW-1] && e[PPN_W +: VPN_W] == vp && e[PPN_W+VPN_W +: PID_W] == p) begin
        eh = 1; ep = e[PPN_W-1:0]; er = n + 1;
        return;
      end
    end
  endtask

  task automatic run(input logic [VPN_W-1:0] vp, input logic [PID_W-1:0] p, input bit junk);
    bit eh; logic [PPN_W-1:0] ep; int er; int n; bit got;
    logic [ADDR_W-1:0] a0;
    expect_search(vp, p, eh, ep, er);
    vpn = vp; pid = p; start = 1;
    @(negedge clk);
    start = 0;
    n = 0; got = 0;
    while (!got && n < 16) begin
      check(mem_req_valid == 1, "R3 request after start/response", mem_req_valid, 1);
      if (!mem_req_valid) break;
      a0 = mem_req_addr;
      repeat ($urandom % 3) @(negedge clk);
      check(mem_req_addr == a0, "R10 address held while stalled", mem_req_addr, a0);
      check(mem_req_addr == tbl_base + ADDR_W'(exp_off(vp, p, n)),
            (n < 8) ? "R2/R3 primary address" : "R6 alternate address",
            mem_req_addr, tbl_base + ADDR_W'(exp_off(vp, p, n)));
      mem_req_ready = 1;
      @(negedge clk);
      mem_req_ready = 0;
      if (junk && n == 1) begin
        vpn = ~vp; pid = ~p; start = 1;
        @(negedge clk);
        start = 0; vpn = vp; pid = p;
      end
      repeat ($urandom % 3) @(negedge clk);
      mem_rsp_valid = 1;
      mem_rsp_data = mem[a0[8:0]];
      @(negedge clk);
      mem_rsp_valid = 0;
      n++;
      got = done;
    end
    check(got, "R7 lookup completes", got, 1);
    check(n == er, "R5/R7 number of reads", n, er);
    check(hit == eh, eh ? "R4/R5 hit flag" : "R7 miss flag", hit, eh);
    check(ppn == ep, "R4/R5 returned ppn", ppn, ep);
    if (junk) check(hit == eh && ppn == ep, "R9 start while busy ignored", ppn, ep);
    @(negedge clk);
    check(done == 0, "R8 done is one cycle", done, 0);
    check(hit == eh && ppn == ep, "R8 result held", ppn, ep);
    check(mem_req_valid == 0 && busy == 0, "R5 no reads after result", mem_req_valid, 0);
  endtask

  task automatic fill_random();
    for (int i = 0; i < 512; i++)
      mem[i] = mk(1'($urandom), PID_W'($urandom), VPN_W'($urandom), PPN_W'($urandom));
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      fails++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [VPN_W-1:0] v; logic [PID_W-1:0] p; logic [5:0] s;
    void'($urandom(32'h5EED_1234));
    rst = 1; start = 0; vpn = '0; pid = '0; mem_req_ready = 0; mem_rsp_valid = 0;
    mem_rsp_data = '0;
    tbl_base = {23'($urandom), 9'd0};
    fill_random();
    repeat (3) @(negedge clk);
    rst = 0;
    check(busy == 0 && done == 0 && mem_req_valid == 0, "R1 reset state",
          {busy, done, mem_req_valid}, 0);
    @(negedge clk);

    // R4/R5: hit in primary entry 0
    v = 20'h1234A; p = 8'h5C; s = prim_of(v, p);
    mem[{s, 3'd0}] = mk(1, p, v, 20'hABCDE);
    run(v, p, 0);
    // R3: hit in last primary entry
    v = 20'h0F0F3; p = 8'h11; s = prim_of(v, p);
    for (int w = 0; w < 8; w++) mem[{s, 3'(w)}] = mk(1, p, v + 1, 20'h1);
    mem[{s, 3'd7}] = mk(1, p, v, 20'h77777);
    run(v, p, 0);
    // R6: hit in alternate slot entry 3
    v = 20'h22222; p = 8'h2A; s = prim_of(v, p);
    for (int w = 0; w < 8; w++) mem[{s, 3'(w)}] = mk(1, p + 1, v, 20'h2);
    mem[{~s, 3'd3}] = mk(1, p, v, 20'h33333);
    run(v, p, 0);
    // R7: full miss with VPN match but PID mismatch and invalid matching entries
    v = 20'h44444; p = 8'h03; s = prim_of(v, p);
    for (int w = 0; w < 8; w++) begin
      mem[{s, 3'(w)}]  = mk(0, p, v, 20'h5);
      mem[{~s, 3'(w)}] = mk(1, p ^ 8'h80, v, 20'h6);
    end
    run(v, p, 0);
    // R5: two valid matches, first one wins; invalid one before them
    v = 20'h55555; p = 8'h44; s = prim_of(v, p);
    for (int w = 0; w < 8; w++) mem[{s, 3'(w)}] = mk(1, p, v ^ 20'h1, 20'h0);
    mem[{s, 3'd1}] = mk(0, p, v, 20'hDEAD0);
    mem[{s, 3'd2}] = mk(1, p, v, 20'h00222);
    mem[{s, 3'd5}] = mk(1, p, v, 20'h00555);
    run(v, p, 1);

    // constrained random lookups
    for (int k = 0; k < 80; k++) begin
      int mode;
      v = VPN_W'($urandom); p = PID_W'($urandom); s = prim_of(v, p);
      mode = $urandom % 4;
      if (mode == 0) mem[{s, 3'($urandom)}] = mk(1, p, v, PPN_W'($urandom));
      if (mode == 1) mem[{~s, 3'($urandom)}] = mk(1, p, v, PPN_W'($urandom));
      if (mode == 3) mem[{s, 3'($urandom)}] = mk(0, p, v, PPN_W'($urandom));
      run(v, p, (k % 7) == 0);
    end

    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule